// File: doc/BRIEF.md
# Sowing Process Sequencing Controller

This block is a synchronous finite-state sequencer that walks a field machine through its working phases: weed removal, seed drilling, seed feeding, fertilizer drilling, fertilizer feeding and soil leveling, then back to idle. Each drilling phase ends on its own depth sensor. The weed phase follows the weed sensor. The two feeding phases run on dedicated countdown timers. The leveling phase runs on a third timer and can also end early when the soil-level sensor reports flat ground.

Four operator shortcut inputs can move the machine straight into a later phase. Three seven-segment displays show the live countdown of the seed-feed, fertilizer-feed and leveling timers. All sensor and shortcut inputs are re-timed through two-flop synchronisers before they reach the state logic. Each timer advances only on its own single-cycle tick enable, which is already in the system clock domain.

Top module: `sow_seq_ctrl`

## Requirements
- R1: While reset is low and just after it is released, the controller is idle, all six phase outputs are low and every display shows the digit 0.
- R2: `machine_on` is low in reset, goes high on the first rising edge after reset is released, and then stays high.
- R3: From idle with no shortcut active, a high weed sensor enters the weed-removal phase and raises `out_weed`.
- R4: The weed-removal phase ends when the weed sensor goes low, and the seed-drilling phase follows.
- R5: Seed drilling ends when the seed depth sensor is high and moves to seed feeding. Fertilizer drilling ends when the fertilizer depth sensor is high and moves to fertilizer feeding.
- R6: Each feeding timer is 4 bits wide. It is loaded with FEED_LOAD (or LEVEL_LOAD) as its phase is entered. It drops by one on each tick of its own tick input while its phase is active and it is non-zero. Its phase ends on the edge after it reads zero: seed feed goes to fertilizer drill, and fertilizer feed goes to leveling. Ticks have no effect outside the phase.
- R7: Leveling ends, returning to idle, when its timer reads zero or the soil-level sensor is high, whichever comes first.
- R8: At most one phase output is high in any cycle.
- R9: Each display shows the hexadecimal digit of its timer while that timer's phase is active, and shows 0 otherwise. Segments are active high, with bit 0 = a through bit 6 = g (0 = 7'h3F, 9 = 7'h6F).
- R10: `jump_req` bit 0 targets seed feed, bit 1 fertilizer drill, bit 2 fertilizer feed and bit 3 leveling. When several bits are set, the lowest-numbered bit wins. A jump is taken, with priority over normal advance, only when its target is later than the current phase (idle counts as earliest). A jump that is not taken has no effect.
- R11: A change on any sensor or shortcut input changes the phase outputs at the third rising edge after the change, never earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| weed_sense | input | 1 | Weed detector |
| seed_depth_ok | input | 1 | Seed drilling depth reached |
| fert_depth_ok | input | 1 | Fertilizer drilling depth reached |
| soil_level_ok | input | 1 | Soil reported level |
| jump_req | input | 4 | Operator shortcuts: bit0 seed feed, bit1 fert drill, bit2 fert feed, bit3 level |
| tick_seed | input | 1 | Seed-feed timer tick enable |
| tick_fert | input | 1 | Fertilizer-feed timer tick enable |
| tick_level | input | 1 | Leveling timer tick enable |
| machine_on | output | 1 | Machine running indicator |
| out_weed | output | 1 | Weed removal active |
| out_seed_drill | output | 1 | Seed drilling active |
| out_seed_feed | output | 1 | Seed feeding active |
| out_fert_drill | output | 1 | Fertilizer drilling active |
| out_fert_feed | output | 1 | Fertilizer feeding active |
| out_level | output | 1 | Soil leveling active |
| seg_seed | output | 7 | Seed-feed timer display |
| seg_fert | output | 7 | Fertilizer-feed timer display |
| seg_level | output | 7 | Leveling timer display |

## Verification
A change on a sensor or shortcut input is due at the phase outputs on the third rising edge after it, because it passes through two synchroniser flops and the state register. A tick changes its timer, and therefore its display, at the next rising edge. `machine_on` rises at the first edge after reset is released. The bench drives inputs on falling edges. It advances a behavioural reference that delays inputs by the same two stages at every rising edge. It compares every output at the following falling edge, so each result is checked in exactly the cycle it is due.

// File: rtl/sow_pkg.sv
package sow_pkg;
  localparam int DIGIT_W  = 4;
  localparam int SEG_W    = 7;
  localparam int N_TIMERS = 3;
  localparam int N_JUMP   = 4;
  localparam int N_SENSE  = 4;
  localparam int N_SYNC   = N_SENSE + N_JUMP;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_WEED   = 3'd1,
    PH_SDRILL = 3'd2,
    PH_SFEED  = 3'd3,
    PH_FDRILL = 3'd4,
    PH_FFEED  = 3'd5,
    PH_LEVEL  = 3'd6
  } phase_e;

  // phase owning timer k: 0 seed feed, 1 fert feed, 2 level
  function automatic phase_e timed_phase(input int k);
    case (k)
      0:       timed_phase = PH_SFEED;
      1:       timed_phase = PH_FFEED;
      default: timed_phase = PH_LEVEL;
    endcase
  endfunction
endpackage

// File: rtl/sow_sync.sv
module sow_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/sow_timer.sv
module sow_timer
  import sow_pkg::*;
#(
  parameter int LOAD = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               active,
  input  logic               tick,
  output logic [DIGIT_W-1:0] count
);
  localparam logic [DIGIT_W-1:0] LOAD_V = DIGIT_W'(LOAD);

  logic [DIGIT_W-1:0] count_d;
  logic               step_en;

  assign step_en = active && tick && (count != '0);

  always_comb begin
    count_d = count;
    if (load)         count_d = LOAD_V;
    else if (step_en) count_d = count - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= count_d;
  end

  AST_TIMER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (count == LOAD_V)); // R6
  AST_TIMER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && active && tick && count != '0) |=> (count == $past(count) - 1'b1)); // R6
  AST_TIMER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !(active && tick)) |=> $stable(count)); // R6
endmodule

// File: rtl/sow_seg7.sv
module sow_seg7
  import sow_pkg::*;
(
  input  logic [DIGIT_W-1:0] digit,
  input  logic               show,
  output logic [SEG_W-1:0]   seg
);
  logic [DIGIT_W-1:0] val;

  assign val = show ? digit : '0;

  // bit0 = a ... bit6 = g, active high
  always_comb begin
    case (val)
      4'h0: seg = 7'h3F;
      4'h1: seg = 7'h06;
      4'h2: seg = 7'h5B;
      4'h3: seg = 7'h4F;
      4'h4: seg = 7'h66;
      4'h5: seg = 7'h6D;
      4'h6: seg = 7'h7D;
      4'h7: seg = 7'h07;
      4'h8: seg = 7'h7F;
      4'h9: seg = 7'h6F;
      4'hA: seg = 7'h77;
      4'hB: seg = 7'h7C;
      4'hC: seg = 7'h39;
      4'hD: seg = 7'h5E;
      4'hE: seg = 7'h79;
      default: seg = 7'h71;
    endcase
  end
endmodule

// File: rtl/sow_seq_ctrl.sv
module sow_seq_ctrl
  import sow_pkg::*;
#(
  parameter int FEED_LOAD  = 9,
  parameter int LEVEL_LOAD = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              weed_sense,
  input  logic              seed_depth_ok,
  input  logic              fert_depth_ok,
  input  logic              soil_level_ok,
  input  logic [N_JUMP-1:0] jump_req,
  input  logic              tick_seed,
  input  logic              tick_fert,
  input  logic              tick_level,
  output logic              machine_on,
  output logic              out_weed,
  output logic              out_seed_drill,
  output logic              out_seed_feed,
  output logic              out_fert_drill,
  output logic              out_fert_feed,
  output logic              out_level,
  output logic [SEG_W-1:0]  seg_seed,
  output logic [SEG_W-1:0]  seg_fert,
  output logic [SEG_W-1:0]  seg_level
);
  logic [N_SYNC-1:0]   raw_in, sync_in;
  logic                weed_s, sdepth_s, fdepth_s, level_s;
  logic [N_JUMP-1:0]   jump_s;
  phase_e              state, state_d, jump_tgt;
  logic                jump_hit;
  logic [N_TIMERS-1:0] tmr_tick, tmr_load, tmr_act, tmr_zero;
  logic [DIGIT_W-1:0]  tmr_cnt [N_TIMERS];
  logic [SEG_W-1:0]    tmr_seg [N_TIMERS];

  assign raw_in = {jump_req, soil_level_ok, fert_depth_ok, seed_depth_ok, weed_sense};

  sow_sync #(.W(N_SYNC)) u_sync (
    .clk (clk), .rst_n (rst_n), .d (raw_in), .q (sync_in)
  );

  assign weed_s   = sync_in[0];
  assign sdepth_s = sync_in[1];
  assign fdepth_s = sync_in[2];
  assign level_s  = sync_in[3];
  assign jump_s   = sync_in[N_SYNC-1:N_SENSE];

  // shortcut select: lowest-numbered request wins
  always_comb begin
    jump_tgt = PH_IDLE;
    jump_hit = 1'b0;
    for (int i = N_JUMP - 1; i >= 0; i--) begin
      if (jump_s[i]) begin
        jump_tgt = phase_e'(3'(int'(PH_SFEED) + i));
        jump_hit = 1'b1;
      end
    end
  end

  always_comb begin
    state_d = state;
    case (state)
      PH_IDLE:   if (weed_s)                  state_d = PH_WEED;
      PH_WEED:   if (!weed_s)                 state_d = PH_SDRILL;
      PH_SDRILL: if (sdepth_s)                state_d = PH_SFEED;
      PH_SFEED:  if (tmr_zero[0])             state_d = PH_FDRILL;
      PH_FDRILL: if (fdepth_s)                state_d = PH_FFEED;
      PH_FFEED:  if (tmr_zero[1])             state_d = PH_LEVEL;
      PH_LEVEL:  if (tmr_zero[2] || level_s)  state_d = PH_IDLE;
      default:                                state_d = PH_IDLE;
    endcase
    if (jump_hit && (jump_tgt > state)) state_d = jump_tgt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= PH_IDLE;
      machine_on <= 1'b0;
    end else begin
      state      <= state_d;
      machine_on <= 1'b1;
    end
  end

  assign tmr_tick = {tick_level, tick_fert, tick_seed};

  for (genvar k = 0; k < N_TIMERS; k++) begin : g_tmr
    localparam phase_e OWN_PH = timed_phase(k);
    localparam int     LD     = (k == N_TIMERS - 1) ? LEVEL_LOAD : FEED_LOAD;

    assign tmr_act[k]  = (state == OWN_PH);
    assign tmr_load[k] = (state_d == OWN_PH) && (state != OWN_PH);
    assign tmr_zero[k] = (tmr_cnt[k] == '0);

    sow_timer #(.LOAD(LD)) u_timer (
      .clk (clk), .rst_n (rst_n), .load (tmr_load[k]),
      .active (tmr_act[k]), .tick (tmr_tick[k]), .count (tmr_cnt[k])
    );

    sow_seg7 u_seg (
      .digit (tmr_cnt[k]), .show (tmr_act[k]), .seg (tmr_seg[k])
    );
  end

  assign seg_seed  = tmr_seg[0];
  assign seg_fert  = tmr_seg[1];
  assign seg_level = tmr_seg[2];

  assign out_weed       = (state == PH_WEED);
  assign out_seed_drill = (state == PH_SDRILL);
  assign out_seed_feed  = (state == PH_SFEED);
  assign out_fert_drill = (state == PH_FDRILL);
  assign out_fert_feed  = (state == PH_FFEED);
  assign out_level      = (state == PH_LEVEL);

  AST_ONE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({out_weed, out_seed_drill, out_seed_feed,
              out_fert_drill, out_fert_feed, out_level})); // R8
  AST_ON_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    machine_on |=> machine_on); // R2
  AST_NO_BACKWARD: assert property (@(posedge clk) disable iff (!rst_n)
    (state != PH_IDLE) |=> (state == PH_IDLE || state >= $past(state))); // R10
  AST_SEED_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    (state != PH_SFEED) |-> (seg_seed == 7'h3F)); // R9
  AST_LEVEL_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PH_LEVEL && level_s && !jump_hit) |=> (state == PH_IDLE)); // R7
endmodule

// File: tb/tb_sow_seq_ctrl.sv
`timescale 1ns/1ps
module tb_sow_seq_ctrl;
  localparam int LOADV = 9;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       weed = 0, sdep = 0, fdep = 0, lvl = 0;
  logic [3:0] jmp = '0;
  logic       tks = 0, tkf = 0, tkl = 0;
  logic       machine_on, o_weed, o_sdrill, o_sfeed, o_fdrill, o_ffeed, o_level;
  logic [6:0] seg_s, seg_f, seg_l;

  int n_chk = 0, n_fail = 0;
  string cur_req = "R3";
  bit done = 0;

  always #4 clk = ~clk;

  sow_seq_ctrl dut (
    .clk (clk), .rst_n (rst_n), .weed_sense (weed), .seed_depth_ok (sdep),
    .fert_depth_ok (fdep), .soil_level_ok (lvl), .jump_req (jmp),
    .tick_seed (tks), .tick_fert (tkf), .tick_level (tkl),
    .machine_on (machine_on), .out_weed (o_weed), .out_seed_drill (o_sdrill),
    .out_seed_feed (o_sfeed), .out_fert_drill (o_fdrill), .out_fert_feed (o_ffeed),
    .out_level (o_level), .seg_seed (seg_s), .seg_fert (seg_f), .seg_level (seg_l)
  );

  // reference model
  int         m_ph, m_on;
  int         m_cnt [3];
  logic [7:0] m_s1, m_s2;

  function automatic logic [6:0] seg_of(input int d);
    case (d)
      0: return 7'h3F;  1: return 7'h06;  2: return 7'h5B;  3: return 7'h4F;
      4: return 7'h66;  5: return 7'h6D;  6: return 7'h7D;  7: return 7'h07;
      8: return 7'h7F;  9: return 7'h6F;  10: return 7'h77; 11: return 7'h7C;
      12: return 7'h39; 13: return 7'h5E; 14: return 7'h79; default: return 7'h71;
    endcase
  endfunction

  function automatic int owner(input int k);
    return (k == 0) ? 3 : (k == 1) ? 5 : 6;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_on = 0; m_s1 = '0; m_s2 = '0;
      for (int k = 0; k < 3; k++) m_cnt[k] = 0;
    end else begin
      int ns, jt;
      logic [2:0] tk;
      tk = {tkl, tkf, tks};
      ns = m_ph;
      if      (m_ph == 0 && m_s2[0])                      ns = 1;
      else if (m_ph == 1 && !m_s2[0])                     ns = 2;
      else if (m_ph == 2 && m_s2[1])                      ns = 3;
      else if (m_ph == 3 && m_cnt[0] == 0)                ns = 4;
      else if (m_ph == 4 && m_s2[2])                      ns = 5;
      else if (m_ph == 5 && m_cnt[1] == 0)                ns = 6;
      else if (m_ph == 6 && (m_cnt[2] == 0 || m_s2[3]))   ns = 0;
      jt = 0;
      for (int i = 0; i < 4; i++) if (jt == 0 && m_s2[4+i]) jt = 3 + i;
      if (jt > m_ph) ns = jt;
      for (int k = 0; k < 3; k++) begin
        if (ns == owner(k) && m_ph != owner(k)) m_cnt[k] = LOADV;
        else if (m_ph == owner(k) && tk[k] && m_cnt[k] != 0) m_cnt[k] = m_cnt[k] - 1;
      end
      m_s2 = m_s1;
      m_s1 = {jmp, lvl, fdep, sdep, weed};
      m_ph = ns;
      m_on = 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [5:0] exp_vec();
    return (m_ph == 0) ? 6'd0 : 6'(1 << (m_ph - 1));
  endfunction

  // compare every cycle away from the rising edge
  always @(negedge clk) begin
    if (!done) begin
      logic [5:0] v;
      v = {o_level, o_ffeed, o_fdrill, o_sfeed, o_sdrill, o_weed};
      check(v == exp_vec(), cur_req, v, exp_vec());
      check($countones(v) <= 1, "R8", v, 0);
      check(machine_on == m_on[0], "R2", machine_on, m_on);
      check(seg_s == seg_of(m_ph == 3 ? m_cnt[0] : 0), "R9", seg_s, seg_of(m_ph == 3 ? m_cnt[0] : 0));
      check(seg_f == seg_of(m_ph == 5 ? m_cnt[1] : 0), "R9", seg_f, seg_of(m_ph == 5 ? m_cnt[1] : 0));
      check(seg_l == seg_of(m_ph == 6 ? m_cnt[2] : 0), "R9", seg_l, seg_of(m_ph == 6 ? m_cnt[2] : 0));
    end
  end

  task automatic cyc(input int n, input int tick_pct);
    repeat (n) begin
      @(negedge clk);
      tks = ($urandom_range(99) < tick_pct);
      tkf = ($urandom_range(99) < tick_pct);
      tkl = ($urandom_range(99) < tick_pct);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=hung exp=done");
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    cur_req = "R1";
    check({o_level, o_ffeed, o_fdrill, o_sfeed, o_sdrill, o_weed} == 6'd0, "R1", 0, 0);
    check(seg_s == 7'h3F && seg_f == 7'h3F && seg_l == 7'h3F, "R1", seg_s, 7'h3F);
    check(machine_on == 1'b0, "R2", machine_on, 0);
    rst_n = 1'b1;
    cyc(3, 50);

    // R11: effect exactly on the third edge after the change
    cur_req = "R11";
    weed = 1;
    @(negedge clk); check(o_weed == 1'b0, "R11", o_weed, 0);
    @(negedge clk); check(o_weed == 1'b0, "R11", o_weed, 0);
    @(negedge clk); check(o_weed == 1'b1, "R3", o_weed, 1);
    cur_req = "R3"; cyc(4, 50);
    cur_req = "R4"; weed = 0; cyc(5, 50);
    cur_req = "R5"; sdep = 1; cyc(4, 0); sdep = 0;
    cur_req = "R6"; cyc(30, 50);
    cur_req = "R5"; fdep = 1; cyc(4, 0); fdep = 0;
    cur_req = "R6"; cyc(30, 50);
    cur_req = "R7"; cyc(30, 60);
    // second run: leveling cut short by the soil sensor
    weed = 1; cyc(5, 0); weed = 0; cyc(4, 0);
    sdep = 1; cyc(4, 0); sdep = 0;
    cur_req = "R6"; cyc(12, 100);
    fdep = 1; cyc(4, 0); fdep = 0; cyc(12, 100);
    cur_req = "R7"; cyc(3, 0); lvl = 1; cyc(6, 0); lvl = 0; cyc(4, 0);

    // R10: shortcuts
    cur_req = "R10";
    jmp = 4'b1010; cyc(8, 80);   // lowest set bit: fert drill
    jmp = 4'b0001; cyc(6, 80);   // earlier target, ignored
    jmp = 4'b0000; cyc(3, 80);
    jmp = 4'b0100; cyc(4, 30); jmp = 4'b0000; cyc(4, 30);
    jmp = 4'b1000; cyc(4, 0);  jmp = 4'b0000;
    cur_req = "R7"; cyc(20, 100);
    cur_req = "R10";
    jmp = 4'b1111; cyc(5, 0); jmp = 4'b0000; cyc(14, 100);
    cyc(20, 100);
    finish_run();
  end
endmodule